// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block sequences a multi-channel analog front end through a window of input channels. Software programs a window (start channel, end channel), a conversion setting for each channel and an enable for each of three trigger sources. Every accepted trigger launches one conversion of the current channel. The block presents that channel's stored setting to the converter, then moves the scan pointer forward. After the end channel the pointer wraps to the start channel. If the end channel is numerically below the start channel, the window passes through the top channel back to zero.

A converted 12-bit value comes back from the converter with a done strobe. The block prefixes it with the channel number it was taken from and offers the tagged word on a valid/ready output. A word that is not yet accepted stays on the output unchanged while `res_ready` is low. The block counts as busy from the start of a conversion until its result is accepted. A trigger that arrives while the block is busy is dropped and raises a sticky overrun flag.

A channel set to differential mode also occupies its odd partner. The scan therefore steps by two past such a channel.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `res_valid`, `adc_start` and `overrun` are 0 and all trigger sources are disabled. The window is channel 0 to channel 0, the pointer is 0 and every channel's setting is all zero.
- R2: A write to register address 2 loads the window. Bits 3:0 give the start channel and bits 11:8 give the end channel. The write also moves the scan pointer to the new start channel.
- R3: A write to register address 3 stores a setting for the channel in the window's start field. Bit 5 selects differential, bit 4 selects unipolar and bits 2:0 give the gain. At each start, `adc_range` carries that channel's setting as {differential, unipolar, gain[2:0]}.
- R4: Each accepted trigger converts the current channel. The pointer then advances by one, and after the end channel it wraps to the start channel, passing from 15 to 0 where the window requires.
- R5: Past a channel marked differential, the pointer advances by two. If that channel or its partner is the end channel, the pointer returns to the start channel.
- R6: Control register address 1 holds the trigger enables. Bit 0 enables the software trigger, which is a write to address 0. Bit 1 enables `pacer_tick`. Bit 2 enables a rising edge of `ext_trig`. A trigger from a disabled source starts nothing and leaves the pointer unchanged.
- R7: A result word is {channel[3:0], value[11:0]}. The word is raised on `res_valid` and stays on the output, held stable, until a cycle in which `res_ready` is high.
- R8: A trigger that arrives while a conversion or an unaccepted result is pending starts nothing and sets `overrun`. `overrun` stays set until the next write to the control register.
- R9: `adc_start` is a single-cycle pulse. It rises in the cycle after the clock edge that accepts the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 sw trigger, 1 control, 2 window, 3 setting |
| wr_data | input | 16 | Register write data |
| pacer_tick | input | 1 | Internal pacer pulse |
| ext_trig | input | 1 | External trigger level (rising edge used) |
| adc_start | output | 1 | Conversion start pulse |
| adc_chan | output | 4 | Channel to convert |
| adc_range | output | 5 | Setting {diff, uni, gain[2:0]} for the converted channel |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | 12 | Converted value, valid with adc_done |
| res_valid | output | 1 | Tagged result valid |
| res_ready | input | 1 | Downstream accepts result |
| res_data | output | 16 | Tagged result {channel, value} |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
A wrong scan pointer shows at the next accepted trigger, because the channel on `adc_chan` and in the result tag is the wrong one. A mis-stored or mis-read setting shows on `adc_range` in that same start cycle. A broken busy tracker shows as an extra `adc_start`, a result word that changes while it is held, or an `overrun` flag that does not match the triggers sent. Each of these shows within the cycles of the conversion in which it occurs.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Register addresses
  localparam logic [1:0] A_SWTRIG = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_WINDOW = 2'd2;
  localparam logic [1:0] A_SETUP  = 2'd3;

  // Per-channel conversion setting
  typedef struct packed {
    logic       diff;
    logic       uni;
    logic [2:0] gain;
  } rng_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_HOLD
  } cst_t;

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CHW = 4,
  parameter int WW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [WW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_ch,
  output logic [2:0]     ctrl_en,
  output logic [CHW-1:0] first_ch,
  output logic [CHW-1:0] last_ch,
  output logic           mux_wr,
  output logic           sw_hit,
  output logic           ctrl_wr,
  output rng_t           rd_rng
);

  localparam int HI_LSB = 8;

  logic setup_wr;
  rng_t wr_rng;
  rng_t rng_q [NCH];

  assign mux_wr   = wr_en && (wr_addr == A_WINDOW);
  assign sw_hit   = wr_en && (wr_addr == A_SWTRIG);
  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign setup_wr = wr_en && (wr_addr == A_SETUP);

  assign wr_rng.diff = wr_data[5];
  assign wr_rng.uni  = wr_data[4];
  assign wr_rng.gain = wr_data[2:0];

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en  <= '0;
      first_ch <= '0;
      last_ch  <= '0;
    end else begin
      if (ctrl_wr) ctrl_en <= wr_data[2:0];
      if (mux_wr) begin
        first_ch <= wr_data[CHW-1:0];
        last_ch  <= wr_data[HI_LSB+CHW-1:HI_LSB];
      end
    end
  end

  // One setting register per channel
  for (genvar g = 0; g < NCH; g++) begin : g_rng
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rng_q[g] <= '0;
      end else if (setup_wr && (first_ch == CHW'(g))) begin
        rng_q[g] <= wr_rng;
      end
    end
  end

  assign rd_rng = rng_q[rd_ch];

endmodule

// File: rtl/adc_scan_ptr.sv
module adc_scan_ptr #(
  parameter int CHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [CHW-1:0] load_ch,
  input  logic           step,
  input  logic           diff_cur,
  input  logic [CHW-1:0] first_ch,
  input  logic [CHW-1:0] last_ch,
  output logic [CHW-1:0] ptr
);

  logic [CHW-1:0] ptr_p1;
  logic [CHW-1:0] ptr_nx;
  logic           at_end;

  assign ptr_p1 = ptr + CHW'(1);
  assign at_end = (ptr == last_ch) || (diff_cur && (ptr_p1 == last_ch));

  always_comb begin
    if (at_end)        ptr_nx = first_ch;
    else if (diff_cur) ptr_nx = ptr + CHW'(2);
    else               ptr_nx = ptr_p1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_ch;
    else if (step) ptr <= ptr_nx;
  end

  // Pointer stays inside the programmed window
  logic [CHW-1:0] off_chk, span_chk;
  assign off_chk  = ptr - first_ch;
  assign span_chk = last_ch - first_ch;

  p_ptr_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    off_chk <= span_chk);

  p_load_sets_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == $past(load_ch)));

endmodule

// File: rtl/adc_scan_trig.sv
module adc_scan_trig (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ctrl_en,
  input  logic       sw_hit,
  input  logic       pacer_tick,
  input  logic       ext_trig,
  output logic       trig
);

  logic ext_q;
  logic ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  assign ext_rise = ext_trig && !ext_q;
  assign trig = (ctrl_en[0] && sw_hit) ||
                (ctrl_en[1] && pacer_tick) ||
                (ctrl_en[2] && ext_rise);

endmodule

// File: rtl/adc_scan_conv.sv
module adc_scan_conv
  import adc_scan_pkg::*;
#(
  parameter int CHW = 4,
  parameter int DW  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             clr_ovr,
  input  logic [CHW-1:0]   cur_ch,
  input  rng_t             cur_rng,
  input  logic             adc_done,
  input  logic [DW-1:0]    adc_data,
  input  logic             res_ready,
  output logic             step,
  output logic             adc_start,
  output logic [CHW-1:0]   adc_chan,
  output rng_t             adc_range,
  output logic             res_valid,
  output logic [CHW+DW-1:0] res_data,
  output logic             overrun
);

  cst_t st;
  logic idle;

  assign idle = (st == ST_IDLE);
  assign step = trig && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      adc_start <= 1'b0;
      adc_chan  <= '0;
      adc_range <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      adc_start <= 1'b0;
      unique case (st)
        ST_IDLE: if (step) begin
          adc_start <= 1'b1;
          adc_chan  <= cur_ch;
          adc_range <= cur_rng;
          st        <= ST_CONV;
        end
        ST_CONV: if (adc_done) begin
          res_data  <= {adc_chan, adc_data};
          res_valid <= 1'b1;
          st        <= ST_HOLD;
        end
        ST_HOLD: if (res_ready) begin
          res_valid <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                overrun <= 1'b0;
    else if (trig && !idle)    overrun <= 1'b1;
    else if (clr_ovr)          overrun <= 1'b0;
  end

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_ovr) |=> overrun);

  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !idle) |=> !adc_start);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 12,
  parameter int WW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int OW  = CHW + DW,
  localparam int RGW = $bits(rng_t)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [WW-1:0]  wr_data,
  input  logic           pacer_tick,
  input  logic           ext_trig,
  output logic           adc_start,
  output logic [CHW-1:0] adc_chan,
  output logic [RGW-1:0] adc_range,
  input  logic           adc_done,
  input  logic [DW-1:0]  adc_data,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [OW-1:0]  res_data,
  output logic           overrun
);

  logic [2:0]     ctrl_en;
  logic [CHW-1:0] first_ch, last_ch, ptr;
  logic           mux_wr, sw_hit, ctrl_wr, trig, step;
  rng_t           cur_rng, rng_out;

  adc_scan_regs #(.NCH(NCH), .CHW(CHW), .WW(WW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_ch(ptr), .ctrl_en(ctrl_en),
    .first_ch(first_ch), .last_ch(last_ch), .mux_wr(mux_wr),
    .sw_hit(sw_hit), .ctrl_wr(ctrl_wr), .rd_rng(cur_rng)
  );

  adc_scan_trig u_trig (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .sw_hit(sw_hit),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .trig(trig)
  );

  adc_scan_ptr #(.CHW(CHW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(mux_wr), .load_ch(wr_data[CHW-1:0]),
    .step(step), .diff_cur(cur_rng.diff), .first_ch(first_ch),
    .last_ch(last_ch), .ptr(ptr)
  );

  adc_scan_conv #(.CHW(CHW), .DW(DW)) u_conv (
    .clk(clk), .rst_n(rst_n), .trig(trig), .clr_ovr(ctrl_wr),
    .cur_ch(ptr), .cur_rng(cur_rng), .adc_done(adc_done),
    .adc_data(adc_data), .res_ready(res_ready), .step(step),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_range(rng_out),
    .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
  );

  assign adc_range = rng_out;

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pacer_tick = 1'b0;
  logic        ext_trig = 1'b0;
  logic        adc_start;
  logic [3:0]  adc_chan;
  logic [4:0]  adc_range;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;
  logic        overrun;

  int errors = 0;
  int checks = 0;
  int lat = 1;
  int stub_cnt = 0;
  int stub_seq = 0;
  int start_cnt = 0;
  logic [3:0] st_ch = '0;
  logic [4:0] st_rng = '0;
  logic [4:0] rmod [16];
  logic [3:0] cur_first = '0;

  always #10 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_range(adc_range),
    .adc_done(adc_done), .adc_data(adc_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .overrun(overrun)
  );

  // Converter stub
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) adc_done <= 1'b1;
    end
    if (adc_start) begin
      stub_cnt  <= lat;
      stub_seq  <= stub_seq + 1;
      adc_data  <= 12'(stub_seq * 37 + int'(adc_chan) * 211 + 5);
      st_ch     <= adc_chan;
      st_rng    <= adc_range;
      start_cnt <= start_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_pacer();
    @(negedge clk); pacer_tick = 1'b1;
    @(negedge clk); pacer_tick = 1'b0;
  endtask

  task automatic wait_valid(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (res_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // Waits for a result already triggered and checks channel, setting and tag
  task automatic expect_result(input logic [3:0] ch, input string tag);
    logic seen;
    wait_valid(seen);
    chk(seen, {tag, " result valid"}, int'(seen), 1);
    chk(st_ch == ch, {tag, " R4 converted channel"}, int'(st_ch), int'(ch));
    chk(st_rng == rmod[ch], {tag, " R3 setting at start"}, int'(st_rng), int'(rmod[ch]));
    chk(res_data == {ch, adc_data}, {tag, " R7 tagged word"}, int'(res_data), int'({ch, adc_data}));
    if (res_ready) @(negedge clk);
  endtask

  // kind 0: window write, 1: setting write, 2: sw trigger expecting channel
  localparam int NV = 30;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 16'h0202, 4'd0}, {2'd1, 16'h0020, 4'd0},
    {2'd0, 16'h0404, 4'd0}, {2'd1, 16'h0013, 4'd0},
    {2'd0, 16'h0505, 4'd0}, {2'd1, 16'h0006, 4'd0},
    {2'd0, 16'h0503, 4'd0}, {2'd2, 16'h0000, 4'd3}, {2'd2, 16'h0000, 4'd4},
    {2'd2, 16'h0000, 4'd5}, {2'd2, 16'h0000, 4'd3},
    {2'd0, 16'h020E, 4'd0}, {2'd2, 16'h0000, 4'd14}, {2'd2, 16'h0000, 4'd15},
    {2'd2, 16'h0000, 4'd0}, {2'd2, 16'h0000, 4'd1}, {2'd2, 16'h0000, 4'd2},
    {2'd2, 16'h0000, 4'd14},
    {2'd0, 16'h0707, 4'd0}, {2'd2, 16'h0000, 4'd7}, {2'd2, 16'h0000, 4'd7},
    {2'd0, 16'h0501, 4'd0}, {2'd2, 16'h0000, 4'd1}, {2'd2, 16'h0000, 4'd2},
    {2'd2, 16'h0000, 4'd4}, {2'd2, 16'h0000, 4'd5}, {2'd2, 16'h0000, 4'd1},
    {2'd0, 16'h0302, 4'd0}, {2'd2, 16'h0000, 4'd2}, {2'd2, 16'h0000, 4'd2}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sc;
    logic seen;
    logic [15:0] held;
    for (int i = 0; i < 16; i++) rmod[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!res_valid, "R1 res_valid after reset", int'(res_valid), 0);
    chk(!adc_start, "R1 adc_start after reset", int'(adc_start), 0);
    chk(!overrun, "R1 overrun after reset", int'(overrun), 0);
    sc = start_cnt;
    wr(2'd0, 16'h0);
    repeat (3) @(negedge clk);
    chk(start_cnt == sc, "R1 triggers disabled after reset", start_cnt, sc);

    // R1 window 0..0, R9 start pulse timing
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0);
    chk(adc_start, "R9 start one cycle after trigger", int'(adc_start), 1);
    @(negedge clk);
    chk(!adc_start, "R9 start is single cycle", int'(adc_start), 0);
    expect_result(4'd0, "R1 default window");

    // Table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  k;
      logic [15:0] d;
      logic [3:0]  e;
      {k, d, e} = VEC[v];
      if (k == 2'd0) begin
        wr(2'd2, d);
        cur_first = d[3:0];
      end else if (k == 2'd1) begin
        wr(2'd3, d);
        rmod[cur_first] = {d[5], d[4], d[2:0]};
      end else begin
        wr(2'd0, 16'h0);
        expect_result(e, $sformatf("R2 R5 vec%0d", v));
      end
    end

    // R6 disabled sources ignored
    wr(2'd2, 16'h0908);
    wr(2'd1, 16'h0000);
    sc = start_cnt;
    wr(2'd0, 16'h0);
    pulse_pacer();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    repeat (3) @(negedge clk);
    chk(start_cnt == sc, "R6 disabled sources start nothing", start_cnt, sc);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0);
    expect_result(4'd8, "R6 pointer unchanged by disabled triggers");
    wr(2'd1, 16'h0002);
    pulse_pacer();
    expect_result(4'd9, "R6 pacer trigger");
    wr(2'd1, 16'h0004);
    sc = start_cnt;
    @(negedge clk); ext_trig = 1'b1;
    expect_result(4'd8, "R6 external edge");
    repeat (4) @(negedge clk);
    ext_trig = 1'b0;
    @(negedge clk);
    chk(start_cnt == sc + 1, "R6 held level triggers once", start_cnt, sc + 1);

    // R8 overrun during conversion
    wr(2'd2, 16'h0B0A);
    wr(2'd1, 16'h0001);
    lat = 6;
    sc = start_cnt;
    wr(2'd0, 16'h0);
    @(negedge clk);
    wr(2'd0, 16'h0);
    chk(overrun, "R8 overrun set on busy trigger", int'(overrun), 1);
    expect_result(4'd10, "R8 first conversion kept");
    chk(start_cnt == sc + 1, "R8 busy trigger started nothing", start_cnt, sc + 1);
    wr(2'd0, 16'h0);
    expect_result(4'd11, "R8 pointer advanced once");
    chk(overrun, "R8 overrun sticky", int'(overrun), 1);
    wr(2'd1, 16'h0001);
    chk(!overrun, "R8 control write clears overrun", int'(overrun), 0);
    lat = 1;

    // R7 back-pressure
    res_ready = 1'b0;
    wr(2'd0, 16'h0);
    wait_valid(seen);
    chk(seen, "R7 result raised", int'(seen), 1);
    held = res_data;
    chk(held == {4'd10, adc_data}, "R7 held word tag", int'(held), int'({4'd10, adc_data}));
    sc = start_cnt;
    wr(2'd0, 16'h0);
    repeat (2) @(negedge clk);
    chk(res_valid && res_data == held, "R7 word held while not ready", int'(res_data), int'(held));
    chk(overrun, "R8 trigger while result held", int'(overrun), 1);
    chk(start_cnt == sc, "R8 no start while result held", start_cnt, sc);
    res_ready = 1'b1;
    @(negedge clk);
    chk(!res_valid, "R7 valid drops after accept", int'(res_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule